// File: doc/BRIEF.md
# Byte-Wide XOR-Composed CRC Engine

This block folds one data byte per clock into a 32-bit cyclic redundancy check. Bits are taken most significant first, so the running remainder shifts left. Each step takes an 8-bit index: the top byte of the running remainder XORed with the incoming byte. The remainder is then shifted left by eight and XORed with the table entry for that index.

No lookup memory holds the 256 entries. The remainder is linear over XOR, so any entry equals the XOR of the entries for the single set bits of its index. Only eight weight constants are needed. They are derived from the polynomial parameter during elaboration, and the entry is formed by combinational XOR selected by the index bits.

Some polynomials have all their low-order terms in one or two bytes, such as a 32-bit check whose remainder polynomial has degree 8 or 16. For these, whole byte lanes of every entry are zero, and the generate logic ties those lanes to zero. A frame begins with `start`, which loads the seed value. Each byte arrives with `byte_valid`. The result, XORed with a fixed output mask, is read on `crc_out`.

Top module: `bytewise_crc_engine`

## Requirements
- R1: In the first cycle after `rst` is released, `crc_out` equals INIT_VAL ^ XOR_OUT.
- R2: `start` high with `byte_valid` low reloads the remainder, and `crc_out` equals INIT_VAL ^ XOR_OUT from the next cycle.
- R3: A cycle with `byte_valid` high folds `data_byte` into the remainder. The result matches eight steps of bit-serial division, taking bit 7 first. In each step the feedback is remainder bit 31 XOR the data bit, the remainder shifts left by one, and it is XORed with POLY when the feedback is 1. `crc_out` shows the new remainder ^ XOR_OUT from the next cycle.
- R4: With `start` and `byte_valid` both low, `crc_out` holds its value.
- R5: `start` and `byte_valid` high together fold the byte into INIT_VAL, not into the previous remainder.
- R6: When the index (remainder bits 31:24 XOR `data_byte`) is 0, the new remainder is the old one shifted left by 8.
- R7: When the index is 1, the new remainder is the old one shifted left by 8, XORed with POLY.
- R8: Some byte lanes have no set bit in any of the eight weights. In those lanes the new remainder equals the old remainder shifted left by 8. For POLY 0x000001ED this covers bits 31:16. For POLY 0x0001B435 it covers bits 31:24.
- R9: With POLY 0x000001ED, the entry for index 0xFE is 0x0000A5B6 and the entry for index 0xFF is 0x0000A45B. With POLY 0x04C11DB7, the entry for index 0xFF is 0xB1F740B4.
- R10: With POLY 0x04C11DB7, INIT_VAL all ones and XOR_OUT zero, the ASCII bytes "123456789" give 0x0376E6E7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame: reload the seed value |
| byte_valid | input | 1 | `data_byte` is to be folded in this cycle |
| data_byte | input | 8 | Data byte |
| crc_out | output | CRC_W | Registered remainder XORed with XOR_OUT |

## Verification
The checker watches four things on every clock:
- the reset and reload values;
- that `crc_out` holds on idle cycles;
- the two smallest indices, where the step must reduce to a plain shift or a shift with the polynomial;
- the byte lanes that the chosen polynomial leaves untouched, which must carry only shifted remainder bits.

Whether the XOR-composed entries are correct for every index can only be shown by the bench scenarios. The bench runs three polynomials in parallel against a bit-serial model, over random frames with idle gaps, published entry values and the standard check string.

// File: rtl/crc_bw_pkg.sv
package crc_bw_pkg;

  localparam int MAX_W = 64;
  typedef logic [MAX_W-1:0] wide_t;

  function automatic wide_t width_mask(int unsigned w);
    wide_t m;
    m = '0;
    for (int k = 0; k < MAX_W; k++) begin
      if (k < int'(w)) m[k] = 1'b1;
    end
    return m;
  endfunction

  // Remainder of (idx * x^(w)) divided by the polynomial, left-shift form
  function automatic wide_t table_entry(int unsigned w, wide_t poly, logic [7:0] idx);
    wide_t r;
    logic  fb;
    r = wide_t'(idx) << (w - 8);
    for (int k = 0; k < 8; k++) begin
      fb = r[w-1];
      r  = (r << 1) & width_mask(w);
      if (fb) r = r ^ (poly & width_mask(w));
    end
    return r;
  endfunction

  // Byte lanes touched by at least one single-bit weight
  function automatic logic [MAX_W/8-1:0] live_lanes(int unsigned w, wide_t poly);
    wide_t acc;
    logic [MAX_W/8-1:0] ln;
    acc = '0;
    for (int i = 0; i < 8; i++) acc = acc | table_entry(w, poly, 8'(1 << i));
    for (int l = 0; l < MAX_W/8; l++) ln[l] = |acc[l*8 +: 8];
    return ln;
  endfunction

  // Bit mask of the lanes no weight reaches
  function automatic wide_t frozen_bits(int unsigned w, wide_t poly);
    logic [MAX_W/8-1:0] ln;
    wide_t m;
    ln = live_lanes(w, poly);
    m  = '0;
    for (int l = 0; l < MAX_W/8; l++) begin
      if (!ln[l]) m[l*8 +: 8] = 8'hFF;
    end
    return m & width_mask(w);
  endfunction

endpackage

// File: rtl/crc_bit_weights.sv
module crc_bit_weights
  import crc_bw_pkg::*;
#(
  parameter int                CRC_W = 32,
  parameter logic [CRC_W-1:0]  POLY  = 32'h000001ED
) (
  output logic [7:0][CRC_W-1:0] weights_o
);

  for (genvar i = 0; i < 8; i++) begin : g_wt
    localparam wide_t WIDE = table_entry(CRC_W, wide_t'(POLY), 8'(1 << i));
    assign weights_o[i] = WIDE[CRC_W-1:0];
  end

endmodule

// File: rtl/crc_entry_xor.sv
module crc_entry_xor #(
  parameter int               CRC_W = 32,
  parameter int               LANES = CRC_W / 8,
  parameter logic [LANES-1:0] LIVE  = '1
) (
  input  logic [7:0]             index_i,
  input  logic [7:0][CRC_W-1:0]  weights_i,
  output logic [CRC_W-1:0]       entry_o
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    if (LIVE[l]) begin : g_live
      logic [7:0] acc;
      always_comb begin
        acc = '0;
        for (int i = 0; i < 8; i++) begin
          if (index_i[i]) acc = acc ^ weights_i[i][l*8 +: 8];
        end
      end
      assign entry_o[l*8 +: 8] = acc;
    end else begin : g_zero
      assign entry_o[l*8 +: 8] = 8'h00;
    end
  end

endmodule

// File: rtl/bytewise_crc_engine.sv
module bytewise_crc_engine
  import crc_bw_pkg::*;
#(
  parameter int               CRC_W    = 32,
  parameter logic [CRC_W-1:0] POLY     = 32'h000001ED,
  parameter logic [CRC_W-1:0] INIT_VAL = '1,
  parameter logic [CRC_W-1:0] XOR_OUT  = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             byte_valid,
  input  logic [7:0]       data_byte,
  output logic [CRC_W-1:0] crc_out
);

  localparam int LANES = CRC_W / 8;
  localparam logic [MAX_W/8-1:0] LIVE_ALL = live_lanes(CRC_W, wide_t'(POLY));
  localparam logic [LANES-1:0]   LIVE     = LIVE_ALL[LANES-1:0];
  localparam logic [CRC_W-1:0]   SEED_OUT = INIT_VAL ^ XOR_OUT;

  logic [7:0][CRC_W-1:0] weights;
  logic [CRC_W-1:0]      out_q;
  logic [CRC_W-1:0]      remainder;
  logic [CRC_W-1:0]      base;
  logic [CRC_W-1:0]      entry;
  logic [CRC_W-1:0]      next_rem;
  logic [7:0]            index;

  crc_bit_weights #(.CRC_W(CRC_W), .POLY(POLY)) u_weights (
    .weights_o (weights)
  );

  // The flop holds the masked value, so crc_out is a register output
  assign remainder = out_q ^ XOR_OUT;
  assign base      = start ? INIT_VAL : remainder;
  assign index     = base[CRC_W-1 -: 8] ^ data_byte;

  crc_entry_xor #(.CRC_W(CRC_W), .LANES(LANES), .LIVE(LIVE)) u_entry (
    .index_i   (index),
    .weights_i (weights),
    .entry_o   (entry)
  );

  assign next_rem = (base << 8) ^ entry;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= SEED_OUT;
    end else if (byte_valid) begin
      out_q <= next_rem ^ XOR_OUT;
    end else if (start) begin
      out_q <= SEED_OUT;
    end
  end

  assign crc_out = out_q;

endmodule

// File: rtl/crc_engine_chk.sv
module crc_engine_chk
  import crc_bw_pkg::*;
#(
  parameter int               CRC_W    = 32,
  parameter logic [CRC_W-1:0] POLY     = 32'h000001ED,
  parameter logic [CRC_W-1:0] INIT_VAL = '1,
  parameter logic [CRC_W-1:0] XOR_OUT  = '1
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             byte_valid,
  input logic [7:0]       data_byte,
  input logic [CRC_W-1:0] crc_out
);

  localparam wide_t            FROZEN_W = frozen_bits(CRC_W, wide_t'(POLY));
  localparam logic [CRC_W-1:0] FROZEN   = FROZEN_W[CRC_W-1:0];

  logic [CRC_W-1:0] rem_now;
  logic [CRC_W-1:0] base_now;
  logic [CRC_W-1:0] shifted;
  logic [7:0]       idx_now;

  assign rem_now  = crc_out ^ XOR_OUT;
  assign base_now = start ? INIT_VAL : rem_now;
  assign shifted  = base_now << 8;
  assign idx_now  = base_now[CRC_W-1 -: 8] ^ data_byte;

  // R1
  reset_value_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> crc_out == (INIT_VAL ^ XOR_OUT));

  // R2
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !byte_valid) |=> crc_out == (INIT_VAL ^ XOR_OUT));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!start && !byte_valid) |=> $stable(crc_out));

  // R6
  zero_index_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && idx_now == 8'h00) |=> rem_now == $past(shifted));

  // R7
  unit_index_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && idx_now == 8'h01) |=> rem_now == ($past(shifted) ^ POLY));

  // R8
  frozen_lane_chk: assert property (@(posedge clk) disable iff (rst)
    byte_valid |=> (rem_now & FROZEN) == ($past(shifted) & FROZEN));

endmodule

bind bytewise_crc_engine crc_engine_chk #(
  .CRC_W(CRC_W), .POLY(POLY), .INIT_VAL(INIT_VAL), .XOR_OUT(XOR_OUT)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .byte_valid (byte_valid),
  .data_byte  (data_byte),
  .crc_out    (crc_out)
);

// File: tb/sim_bytewise_crc_engine.sv
module sim_bytewise_crc_engine;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;
  localparam int NUM_INST   = 3;

  localparam logic [31:0] POLYS [NUM_INST] = '{32'h000001ED, 32'h0001B435, 32'h04C11DB7};
  localparam logic [31:0] INITS [NUM_INST] = '{32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF};
  localparam logic [31:0] XORS  [NUM_INST] = '{32'h00000000, 32'hFFFFFFFF, 32'h00000000};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       byte_valid = 1'b0;
  logic [7:0] data_byte = 8'h00;
  logic [31:0] crc0, crc1, crc2;
  logic [31:0] outs  [NUM_INST];
  logic [31:0] model [NUM_INST];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bytewise_crc_engine #(.CRC_W(32), .POLY(POLYS[0]), .INIT_VAL(INITS[0]), .XOR_OUT(XORS[0])) u0 (
    .clk(clk), .rst(rst), .start(start), .byte_valid(byte_valid), .data_byte(data_byte), .crc_out(crc0));
  bytewise_crc_engine #(.CRC_W(32), .POLY(POLYS[1]), .INIT_VAL(INITS[1]), .XOR_OUT(XORS[1])) u1 (
    .clk(clk), .rst(rst), .start(start), .byte_valid(byte_valid), .data_byte(data_byte), .crc_out(crc1));
  bytewise_crc_engine #(.CRC_W(32), .POLY(POLYS[2]), .INIT_VAL(INITS[2]), .XOR_OUT(XORS[2])) u2 (
    .clk(clk), .rst(rst), .start(start), .byte_valid(byte_valid), .data_byte(data_byte), .crc_out(crc2));

  assign outs[0] = crc0;
  assign outs[1] = crc1;
  assign outs[2] = crc2;

  function automatic logic [31:0] serial_step(logic [31:0] poly, logic [31:0] c, logic [7:0] d);
    logic [31:0] r;
    logic fb;
    r = c;
    for (int b = 7; b >= 0; b--) begin
      fb = r[31] ^ d[b];
      r  = r << 1;
      if (fb) r = r ^ poly;
    end
    return r;
  endfunction

  task automatic check(string tag, int k, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s inst %0d: actual %08h expected %08h", tag, k, act, exp);
    end
  endtask

  // Drive at negedge, update model at posedge, compare at next negedge
  task automatic step(logic st, logic v, logic [7:0] d);
    string tag;
    start = st; byte_valid = v; data_byte = d;
    @(posedge clk);
    for (int k = 0; k < NUM_INST; k++) begin
      if (v)       model[k] = serial_step(POLYS[k], st ? INITS[k] : model[k], d);
      else if (st) model[k] = INITS[k];
    end
    @(negedge clk);
    start = 1'b0; byte_valid = 1'b0;
    tag = v ? (st ? "R5" : "R3") : (st ? "R2" : "R4");
    for (int k = 0; k < NUM_INST; k++) check(tag, k, outs[k], model[k] ^ XORS[k]);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] prev, prev1;
    logic [7:0]  msg [9];
    void'($urandom(32'd20061));
    for (int k = 0; k < NUM_INST; k++) model[k] = INITS[k];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset value visible right after release
    for (int k = 0; k < NUM_INST; k++) check("R1", k, outs[k], INITS[k] ^ XORS[k]);
    step(1'b0, 1'b0, 8'h5A);

    // R9: known entries, seeded from zero or all ones
    step(1'b1, 1'b1, 8'hFE);
    check("R9", 0, crc0, 32'h0000A5B6);
    step(1'b1, 1'b1, 8'hFF);
    check("R9", 0, crc0, 32'h0000A45B);
    step(1'b1, 1'b1, 8'h01);
    check("R7", 0, crc0, 32'h000001ED);
    step(1'b1, 1'b1, 8'h00);
    check("R9", 2, crc2, 32'hFFFFFF00 ^ 32'hB1F740B4);

    // R2: reload without data
    step(1'b1, 1'b0, 8'h33);

    // R10: check string
    msg = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    for (int i = 0; i < 9; i++) step(i == 0, 1'b1, msg[i]);
    check("R10", 2, crc2, 32'h0376E6E7);
    step(1'b0, 1'b0, 8'hAA);

    // R6 / R7: index 0 and index 1 per polynomial
    for (int k = 0; k < NUM_INST; k++) begin
      prev = model[k];
      step(1'b0, 1'b1, prev[31:24]);
      check("R6", k, outs[k], (prev << 8) ^ XORS[k]);
      prev = model[k];
      step(1'b0, 1'b1, prev[31:24] ^ 8'h01);
      check("R7", k, outs[k], ((prev << 8) ^ POLYS[k]) ^ XORS[k]);
    end

    // R8: untouched lanes carry shifted bits only
    for (int n = 0; n < 4; n++) begin
      prev  = model[0];
      prev1 = model[1];
      step(1'b0, 1'b1, 8'($urandom));
      check("R8", 0, {16'h0, (crc0 ^ XORS[0]) >> 16}, {16'h0, prev[23:8]});
      check("R8", 1, {24'h0, (crc1 ^ XORS[1]) >> 24}, {24'h0, prev1[23:16]});
    end

    // R3 / R4 / R5: random frames with idle gaps
    for (int m = 0; m < 30; m++) begin
      int len;
      len = 1 + $urandom_range(255);
      for (int i = 0; i < len; i++) begin
        if (i != 0 && $urandom_range(3) == 0) step(1'b0, 1'b0, 8'($urandom));
        step(i == 0, 1'b1, 8'($urandom));
      end
      if ($urandom_range(1) == 0) step(1'b1, 1'b0, 8'h00);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule